// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a single service line driven by a processor and raises an expiry request when the software stops toggling it. Any level change on the line, whether it goes up or down, counts as a service kick and restarts the timeout window. If the line stays at one level for a full window, the block emits a one-clock expiry pulse for the downstream reset generator. The counter then reloads and starts a fresh window.

The service line arrives from outside the clock domain. It passes through a two-stage synchronizer, and an edge is found by comparing the synchronized level with a registered copy of itself. Time is counted in ticks from a free-running prescaler. The window length is fixed at elaboration by a parameter that selects between a short tick count and a long tick count. Two on-chip status inputs, one for system reset and one for manual reset, hold the prescaler and the counter at zero for as long as either is high. Counting starts again from zero as soon as both are low.

The clock must be fast enough that the narrowest valid service pulse, about 150 ns, spans at least one full clock period. At 125 MHz a pulse one clock wide is enough.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst` is high, `expire_o` is 0. After `rst` falls with the service line steady, the first expiry appears TICKS*PRESCALE clock edges after the first edge at which `rst` is low.
- R2: A rising change and a falling change on `wdi_i` each restart the timeout window.
- R3: With `wdi_i` steady after a change, `expire_o` is high after exactly the (TICKS*PRESCALE+3)-th rising clock edge, counting the first edge after the change as edge 1. No expiry occurs earlier in that window.
- R4: `expire_o` is high for exactly one clock cycle. The counter reloads to zero in the same cycle, so with no further kick the next expiry follows TICKS*PRESCALE edges later.
- R5: While `man_rst_i` is high, `expire_o` stays 0 for any duration. After it falls, counting restarts from zero and the first expiry comes TICKS*PRESCALE edges after release.
- R6: `sys_rst_i` holds the timer cleared and frozen in the same way as `man_rst_i`, with the same restart timing after it falls.
- R7: If a kick and the terminal tick are resolved at the same clock edge, the kick wins. No expiry is issued and a full new window begins.
- R8: A high pulse on `wdi_i` lasting one clock period is seen as two edges. The window restarts from the falling change, so expiry follows TICKS*PRESCALE+4 edges after the rising change.
- R9: Parameter `SPAN` selects the window length: SPAN_SHORT (0) uses SHORT_TICKS and SPAN_LONG (1) uses LONG_TICKS.
- R10: Changes on `wdi_i` made while a hold input is high, and at least three cycles before the hold is released, have no effect on the window that follows the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wdi_i | input | 1 | Asynchronous service line from the processor |
| sys_rst_i | input | 1 | High while system reset is asserted; clears and freezes the timer |
| man_rst_i | input | 1 | High while manual reset is asserted; clears and freezes the timer |
| expire_o | output | 1 | One-cycle pulse requesting a reset when the window elapses |

## Verification
The bench counts clock edges from each input change to the expiry pulse. An off-by-one in the synchronizer, the prescaler or the terminal compare therefore shows up as a wrong count, not as a missing pulse. It drives a kick at exactly the edge where the terminal tick lands. A design that let the expiry win there would pulse two edges into the new window. It sends a service pulse one clock wide; a design that reacts to only one polarity would expire one edge early. It also holds each reset input longer than a full window while toggling the service line. A counter that kept running or remembered those toggles would pulse during the hold or at the wrong time after release. A stretched pulse or a counter that fails to reload shows up as a wrong gap between two consecutive expiries.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic {
        SPAN_SHORT = 1'b0,
        SPAN_LONG  = 1'b1
    } wd_span_e;

    // Control presented to the window counter each cycle
    typedef struct packed {
        logic clear;    // hold or kick: reload to zero, no expiry
        logic advance;  // one prescaled tick elapsed
    } tick_ctl_t;

    function automatic int span_ticks(wd_span_e s, int short_t, int long_t);
        return (s == SPAN_LONG) ? long_t : short_t;
    endfunction

    // Bits needed to hold values 0 .. n-1
    function automatic int width_for(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdk_edge_sync.sv
module wdk_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic edge_o
);
    logic meta_q;
    logic level_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            level_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            meta_q  <= raw_i;
            level_q <= meta_q;
            prev_q  <= level_q;
        end
    end

    // Either polarity of change is a kick
    assign edge_o = level_q ^ prev_q;

endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
    import wdk_pkg::*;
#(
    parameter int PRESCALE = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = width_for(PRESCALE);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == PW'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(pre_q) < PRESCALE);

endmodule

// File: rtl/wdk_window_counter.sv
module wdk_window_counter
    import wdk_pkg::*;
#(
    parameter int LIMIT = 3300
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_ctl_t ctl_i,
    output logic      expire_o
);
    localparam int CW = width_for(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          at_end;
    logic          expire_q;

    assign at_end   = (cnt_q == CW'(LIMIT - 1));
    assign expire_o = expire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (ctl_i.clear) begin
                cnt_q <= '0;
            end else if (ctl_i.advance) begin
                if (at_end) begin
                    cnt_q    <= '0;
                    expire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < LIMIT);

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> (cnt_q == '0));

    p_kick_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ctl_i.clear |=> !expire_q);

endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
    import wdk_pkg::*;
#(
    parameter int       PRESCALE    = 125000,
    parameter int       SHORT_TICKS = 3300,
    parameter int       LONG_TICKS  = 209000,
    parameter wd_span_e SPAN        = SPAN_SHORT
) (
    input  logic clk,
    input  logic rst,
    input  logic wdi_i,
    input  logic sys_rst_i,
    input  logic man_rst_i,
    output logic expire_o
);
    localparam int LIMIT = span_ticks(SPAN, SHORT_TICKS, LONG_TICKS);

    logic      kick;
    logic      hold;
    logic      tick;
    tick_ctl_t ctl;

    assign hold = sys_rst_i | man_rst_i;

    wdk_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (wdi_i),
        .edge_o (kick)
    );

    wdk_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (hold | kick),
        .tick_o (tick)
    );

    always_comb begin
        ctl.clear   = hold | kick;
        ctl.advance = tick;
    end

    wdk_window_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (ctl),
        .expire_o (expire_o)
    );

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);

    p_hold_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        hold |=> !expire_o);

endmodule

// File: tb/sim_edge_watchdog.sv
module sim_edge_watchdog;
    import wdk_pkg::*;

    localparam int P  = 4;
    localparam int S  = 6;
    localparam int L  = 15;
    localparam int WS = S * P;
    localparam int WL = L * P;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wdi = 1'b0;
    logic sys_r = 1'b0;
    logic man_r = 1'b0;
    logic e0;
    logic e1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    edge_watchdog #(.PRESCALE(P), .SHORT_TICKS(S), .LONG_TICKS(L), .SPAN(SPAN_SHORT)) u0 (
        .clk(clk), .rst(rst), .wdi_i(wdi), .sys_rst_i(sys_r), .man_rst_i(man_r), .expire_o(e0));

    edge_watchdog #(.PRESCALE(P), .SHORT_TICKS(S), .LONG_TICKS(L), .SPAN(SPAN_LONG)) u1 (
        .clk(clk), .rst(rst), .wdi_i(wdi), .sys_rst_i(sys_r), .man_rst_i(man_r), .expire_o(e1));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_to_pulse(input bit use_long, input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if ((use_long ? e1 : e0) === 1'b1) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        check("R1 expiry low in reset (short)", int'(e0), 0);
        check("R1 expiry low in reset (long)", int'(e1), 0);
        rst = 1'b0;
        count_to_pulse(1'b0, 500, n);
        check("R1 first expiry after reset release", n, WS);
    endtask

    task automatic t_rise();
        int n;
        @(negedge clk);
        wdi = 1'b1;
        count_to_pulse(1'b0, 500, n);
        check("R2/R3 rising change latency", n, WS + 3);
    endtask

    task automatic t_fall_and_reload();
        int n;
        @(negedge clk);
        wdi = 1'b0;
        count_to_pulse(1'b0, 500, n);
        check("R2/R3 falling change latency", n, WS + 3);
        count_to_pulse(1'b0, 500, n);
        check("R4 single pulse and reload gap", n, WS);
    endtask

    task automatic t_hold(input bit use_sys, input string req);
        int n;
        int bad = 0;
        @(negedge clk);
        if (use_sys) sys_r = 1'b1; else man_r = 1'b1;
        for (int i = 0; i < 2 * WS; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (e0 !== 1'b0) bad++;
            if (i == 10) wdi = ~wdi;
            if (i == 20) wdi = ~wdi;
            if (i == 30) wdi = ~wdi;
        end
        check({req, " no expiry while held"}, bad, 0);
        if (use_sys) sys_r = 1'b0; else man_r = 1'b0;
        count_to_pulse(1'b0, 500, n);
        check({req, "/R10 restart from zero after release"}, n, WS);
    endtask

    task automatic t_collide();
        int n;
        @(negedge clk);
        wdi = ~wdi;
        repeat (WS) @(posedge clk);
        @(negedge clk);
        wdi = ~wdi;
        count_to_pulse(1'b0, 500, n);
        check("R7 kick at terminal tick wins", n, WS + 3);
    endtask

    task automatic t_narrow();
        int n;
        @(negedge clk);
        wdi = 1'b0;
        repeat (5) @(negedge clk);
        wdi = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wdi = 1'b0;
        count_to_pulse(1'b0, 500, n);
        check("R8 one-clock pulse seen as two edges", n + 1, WS + 4);
    endtask

    task automatic t_long();
        int n;
        @(negedge clk);
        wdi = ~wdi;
        count_to_pulse(1'b1, 500, n);
        check("R9 long span latency", n, WL + 3);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall_and_reload();
        t_hold(1'b0, "R5");
        t_hold(1'b1, "R6");
        t_collide();
        t_narrow();
        t_long();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule